// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog peripheral with five 16-bit registers on a simple single-cycle write and combinational read port. Software programs a timeout in units of a slow tick and turns the watchdog on. From then on it must keep the countdown alive by writing a two-word key sequence to the service register. If the countdown reaches zero while the watchdog is enabled, the block records a timeout in its status register and emits a one-clock system reset request.

The enable bit is write-once: after it is set, nothing short of a block reset clears it. The interrupt-control register accepts exactly one configuring write after reset. After that, only its write-1-to-clear status bit responds.

Software can also request a reset directly through the control register. As an option, software can enable an early-warning interrupt that fires a programmed number of ticks before expiry.

The slow tick comes from a parameterised clock divider. The divider restarts each time the countdown is loaded, so the expiry time is an exact number of clocks after the write that loaded it.

Top module: `wdog_top`

## Requirements
- R1: After reset the registers read: control (address 0) 0x0030, service (address 1) 0x0000, status (address 2) 0x0000, interrupt control (address 3) 0x0004, misc (address 4) 0x0001.
- R2: Control bit 2 is the enable. Once it has been written as 1, later control writes cannot clear it until reset.
- R3: The control write loads the countdown with bits 15:8 plus one. With enable set and a nonzero field, the block expires exactly (field+1)×TICK_DIV clocks after that write. On expiry it sets status bit 1 (timeout), clears status bit 0, and raises reset_req for exactly one clock.
- R4: The countdown reloads from the timeout field only when a service write of 0xAAAA directly follows a service write of 0x5555. Any other sequence leaves the countdown running. The service register reads back the last value written.
- R5: A control write with bit 4 = 0 sets status bit 0 (software flag), clears status bit 1, and raises reset_req on the next clock. Control bit 4 always reads back as 1. Writing bits 5 and 4 both as 0 is a case of this.
- R6: A control write that leaves the enable set with a zero timeout field raises reset_req on the next clock.
- R7: The first write to interrupt control after reset stores bit 15 (interrupt enable) and bits 7:0 (pre-timeout count), then locks. Later writes change neither field. Writing 1 to bit 14 clears the interrupt status, both before and after the lock.
- R8: When the interrupt is enabled and the loaded count exceeds the pre-timeout count, bit 14 and irq go high when the remaining count reaches the pre-timeout count. If the loaded count does not exceed the pre-timeout count, no interrupt fires.
- R9: Writes to the status register are ignored. The misc register keeps only bit 0 (power-down enable) of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Write strobe, one clock per write |
| addr | input | ADDR_W | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| irq | output | 1 | Pre-timeout interrupt, level |
| reset_req | output | 1 | One-clock system reset request |

## Verification
The bench builds the block with TICK_DIV = 4, so one count lasts four clocks. A full expiry then takes a few dozen clocks, and every expiry and pre-timeout edge can be checked to the exact clock rather than a window. The key addresses and values keep their defaults. This covers both the correct service sequence and sequences broken by an intervening word, each measured against a predicted expiry cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W     = 16;
    localparam int TO_LSB     = 8;
    localparam int TO_W       = 8;
    localparam int BIT_EN     = 2;
    localparam int BIT_SRS    = 4;
    localparam int BIT_EXT    = 5;
    localparam int ICR_EN_BIT = 15;
    localparam int ICR_ST_BIT = 14;

    localparam int A_CTRL = 0;
    localparam int A_SVC  = 1;
    localparam int A_STAT = 2;
    localparam int A_ICR  = 3;
    localparam int A_MISC = 4;

    localparam logic [DATA_W-1:0] CTRL_RST = 16'h0030;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] svc;
        logic              tout;
        logic              sft;
        logic              icr_en;
        logic              icr_st;
        logic [TO_W-1:0]   icr_pre;
        logic              icr_lock;
        logic              pdn;
        logic              rreq;
    } wd_state_t;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] div_d, div_q;

    always_comb begin
        tick  = (div_q == W'(DIV - 1));
        div_d = (restart || tick) ? '0 : div_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 9,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             arm_eval,
    input  logic             pre_en,
    input  logic [PRE_W-1:0] pre_val,
    output logic             expire,
    output logic             pre_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             pend;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic [CNT_W-1:0] pre_ext;

    assign pre_ext = CNT_W'(pre_val);

    always_comb begin
        s_d       = s_q;
        s_d.armed = s_q.armed && pre_en;
        s_d.pend  = 1'b0;
        expire    = 1'b0;
        pre_hit   = 1'b0;
        if (load) begin
            s_d.cnt   = load_val;
            s_d.armed = 1'b0;
            s_d.pend  = 1'b1;
        end else begin
            if (arm_eval) s_d.pend = 1'b1;
            if (s_q.pend) s_d.armed = pre_en && run && (s_q.cnt > pre_ext);
            if (run && tick && (s_q.cnt != '0)) begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
                expire  = (s_q.cnt == CNT_W'(1));
                if (s_q.armed && pre_en && (s_q.cnt - CNT_W'(1) == pre_ext)) begin
                    pre_hit   = 1'b1;
                    s_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int              TICK_DIV = 50_000_000,
    parameter int              ADDR_W   = 3,
    parameter logic [15:0]     KEY_A    = 16'h5555,
    parameter logic [15:0]     KEY_B    = 16'hAAAA,
    parameter logic [7:0]      PRE_DEF  = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              irq,
    output logic              reset_req
);
    localparam int CNT_W = TO_W + 1;

    wd_state_t s_d, s_q;

    logic wr_ctrl, wr_svc, wr_stat, wr_icr, wr_misc;
    logic [15:0] ctrl_wv;
    logic key_ok, run_q, load, tick, expire, pre_hit;
    logic [CNT_W-1:0] load_val;

    assign wr_ctrl = we && (addr == ADDR_W'(A_CTRL));
    assign wr_svc  = we && (addr == ADDR_W'(A_SVC));
    assign wr_stat = we && (addr == ADDR_W'(A_STAT));
    assign wr_icr  = we && (addr == ADDR_W'(A_ICR));
    assign wr_misc = we && (addr == ADDR_W'(A_MISC));

    // enable is sticky, soft-reset bit always restored
    assign ctrl_wv = wdata | (16'(s_q.ctrl[BIT_EN]) << BIT_EN) | (16'd1 << BIT_SRS);
    assign run_q   = s_q.ctrl[BIT_EN] && (s_q.ctrl[TO_LSB +: TO_W] != '0);
    assign key_ok  = wr_svc && (s_q.svc == KEY_A) && (wdata == KEY_B);
    assign load    = wr_ctrl || (key_ok && run_q);
    assign load_val = wr_ctrl ? CNT_W'(wdata[TO_LSB +: TO_W]) + CNT_W'(1)
                              : CNT_W'(s_q.ctrl[TO_LSB +: TO_W]) + CNT_W'(1);

    wdog_tick #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (tick)
    );

    wdog_counter #(.CNT_W(CNT_W), .PRE_W(TO_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run_q),
        .load     (load),
        .load_val (load_val),
        .arm_eval (wr_icr),
        .pre_en   (s_q.icr_en),
        .pre_val  (s_q.icr_pre),
        .expire   (expire),
        .pre_hit  (pre_hit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.rreq = 1'b0;
        if (wr_ctrl) begin
            s_d.ctrl = ctrl_wv;
            if (!wdata[BIT_SRS]) begin
                s_d.sft  = 1'b1;
                s_d.tout = 1'b0;
                s_d.rreq = 1'b1;
            end
            if (ctrl_wv[BIT_EN] && (wdata[TO_LSB +: TO_W] == '0)) s_d.rreq = 1'b1;
        end
        if (wr_svc) s_d.svc = wdata;
        if (wr_icr) begin
            if (!s_q.icr_lock) begin
                s_d.icr_en   = wdata[ICR_EN_BIT];
                s_d.icr_pre  = wdata[TO_W-1:0];
                s_d.icr_lock = 1'b1;
            end
            if (wdata[ICR_ST_BIT]) s_d.icr_st = 1'b0;
        end
        if (wr_misc) s_d.pdn = wdata[0];
        if (expire) begin
            s_d.tout = 1'b1;
            s_d.sft  = 1'b0;
            s_d.rreq = 1'b1;
        end
        if (pre_hit) s_d.icr_st = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.ctrl     <= CTRL_RST;
            s_q.icr_pre  <= PRE_DEF;
            s_q.pdn      <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (!wr_stat) begin
            case (int'(addr))
                A_CTRL: rdata = s_q.ctrl;
                A_SVC:  rdata = s_q.svc;
                A_STAT: rdata = {14'd0, s_q.tout, s_q.sft};
                A_ICR:  rdata = {s_q.icr_en, s_q.icr_st, 6'd0, s_q.icr_pre};
                A_MISC: rdata = {15'd0, s_q.pdn};
                default: rdata = '0;
            endcase
        end else begin
            rdata = {14'd0, s_q.tout, s_q.sft};
        end
    end

    assign irq       = s_q.icr_st;
    assign reset_req = s_q.rreq;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata,
    input logic [15:0]       rdata,
    input logic              irq,
    input logic              reset_req,
    input logic              en_q,
    input logic              icr_lock,
    input logic              icr_en,
    input logic [7:0]        icr_pre,
    input logic [1:0]        stat
);
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> en_q);                                              // R2
    AST_TOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> reset_req);                                      // R3
    AST_STAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat));                                                    // R3
    AST_SRS_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && addr == ADDR_W'(0)) |-> rdata[4]);                          // R5
    AST_SRS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(0) && !wdata[4]) |=> reset_req);             // R5
    AST_ZERO_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(0) && (wdata[2] || en_q) && wdata[15:8] == 8'd0) |=> reset_req); // R6
    AST_ICR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(icr_lock) |-> ($stable(icr_en) && $stable(icr_pre)));         // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> icr_en);                                             // R8
endmodule

bind wdog_top wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq       (irq),
    .reset_req (reset_req),
    .en_q      (s_q.ctrl[2]),
    .icr_lock  (s_q.icr_lock),
    .icr_en    (s_q.icr_en),
    .icr_pre   (s_q.icr_pre),
    .stat      ({s_q.tout, s_q.sft})
);

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [2:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic irq, reset_req;
    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    wdog_top #(.TICK_DIV(DIV), .ADDR_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .reset_req(reset_req)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  a;
        logic [15:0] d;
        logic [15:0] e;
        logic [3:0]  r;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{1'b0, 3'd0, 16'h0000, 16'h0030, 4'd1},  // R1 control
        '{1'b0, 3'd1, 16'h0000, 16'h0000, 4'd1},  // R1 service
        '{1'b0, 3'd2, 16'h0000, 16'h0000, 4'd1},  // R1 status
        '{1'b0, 3'd3, 16'h0000, 16'h0004, 4'd1},  // R1 irq control
        '{1'b0, 3'd4, 16'h0000, 16'h0001, 4'd1},  // R1 misc
        '{1'b1, 3'd4, 16'hFFFE, 16'h0000, 4'd9},  // R9 misc keeps bit 0
        '{1'b1, 3'd2, 16'hFFFF, 16'h0000, 4'd9},  // R9 status ignores writes
        '{1'b1, 3'd3, 16'h8010, 16'h8010, 4'd7},  // R7 first write
        '{1'b1, 3'd3, 16'h0003, 16'h8010, 4'd7},  // R7 locked
        '{1'b1, 3'd0, 16'h0330, 16'h0330, 4'd3},  // R3 field store
        '{1'b1, 3'd0, 16'h0334, 16'h0334, 4'd2},  // R2 enable set
        '{1'b1, 3'd0, 16'h0730, 16'h0734, 4'd2},  // R2 enable sticks
        '{1'b1, 3'd1, 16'h5555, 16'h5555, 4'd4},  // R4 readback
        '{1'b1, 3'd0, 16'h0720, 16'h0734, 4'd5},  // R5 bit 4 reads 1
        '{1'b0, 3'd2, 16'h0000, 16'h0001, 4'd5}   // R5 software flag
    };

    task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_sig(input bit use_irq, input int start, output int k);
        k = start;
        while (!(use_irq ? irq : reset_req) && k < 400) begin
            @(posedge clk);
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        #2_000_000;
        total++; fails++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int k;
        @(negedge clk);
        do_reset();
        chk(1, {30'd0, irq, reset_req}, 32'd0, "outputs idle after reset"); // R1

        foreach (VECS[i]) begin
            if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
            rd(VECS[i].a, v);
            chk(int'(VECS[i].r), v, VECS[i].e, $sformatf("vector %0d", i));
        end

        // R3: expiry timing, status and pulse width
        do_reset();
        wr(0, 16'h0234);
        wait_sig(0, 0, k);
        chk(3, k, 3 * DIV, "expiry cycle");
        rd(2, v);
        chk(3, v, 16'h0002, "timeout flag");
        @(posedge clk); @(negedge clk);
        chk(3, reset_req, 0, "reset_req one clock");

        // R4: correct key sequence reloads
        do_reset();
        wr(0, 16'h0334);
        repeat (8) @(negedge clk);
        wr(1, 16'h5555);
        wr(1, 16'hAAAA);
        wait_sig(0, 0, k);
        chk(4, k, 4 * DIV, "reload by key sequence");

        // R4: reversed order does not reload
        do_reset();
        wr(0, 16'h0334);
        wr(1, 16'hAAAA);
        wr(1, 16'h5555);
        wait_sig(0, 2, k);
        chk(4, k, 4 * DIV, "reversed keys ignored");

        // R4: interrupted sequence does not reload
        do_reset();
        wr(0, 16'h0334);
        wr(1, 16'h5555);
        wr(1, 16'h0000);
        wr(1, 16'hAAAA);
        wait_sig(0, 3, k);
        chk(4, k, 4 * DIV, "interrupted keys ignored");

        // R5: both reset bits written as zero
        do_reset();
        wr(0, 16'h0000);
        chk(5, reset_req, 1, "request on soft reset");
        rd(2, v);
        chk(5, v, 16'h0001, "software flag");
        rd(0, v);
        chk(5, v, 16'h0010, "soft-reset bit restored");

        // R6: enable with zero field
        do_reset();
        wr(0, 16'h0034);
        chk(6, reset_req, 1, "request on zero timeout");
        rd(2, v);
        chk(6, v, 16'h0000, "no flag on zero timeout");

        // R8: pre-timeout fires at programmed count
        do_reset();
        wr(3, 16'h8002);
        wr(0, 16'h0534);
        wait_sig(1, 0, k);
        chk(8, k, 4 * DIV, "pre-timeout cycle");
        rd(3, v);
        chk(8, v, 16'hC002, "status bit set");
        // R7: write-1-to-clear after lock
        wr(3, 16'h4000);
        chk(7, irq, 0, "irq cleared");
        rd(3, v);
        chk(7, v, 16'h8002, "fields held");

        // R8: not armed when count does not exceed pre-timeout
        do_reset();
        wr(3, 16'h8008);
        wr(0, 16'h0334);
        wait_sig(0, 0, k);
        chk(8, k, 4 * DIV, "expiry without pre-timeout");
        chk(8, irq, 0, "no interrupt when unarmed");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule